// File: doc/BRIEF.md
# Root Port Power-Up Reset Sequencer

This block takes a root port from full reset to a trained link on one start pulse. It walks a fixed, timed order. It holds the endpoint in reset, gates the port's clocks on, and raises the power enable. It then releases the interface reset and switches on the reference clock. After that it lets the PHY, core, power-on and bus-clock domains out of reset, one domain per clock. After a clock-acquisition wait it frees the endpoint and enables link training. Finally it polls a link-up input at a fixed interval for a bounded number of samples.

All waits are given in microseconds and turned into clock cycles from a clock-frequency parameter, so a bench can use short counts. The sequence ends in one of two sticky states. In the success state every enable stays on and every reset stays released. In the failure state the block puts every reset back and drops every enable. Either state holds until the next start pulse.

Top module: `rp_pwrup_seq`

## Requirements
- R1: After synchronous reset, and while idle, `ep_rst_n` is 0, `ifc_rst`, `phy_rst`, `core_rst`, `por_rst` and `bus_rst` are 1, and `clk_en`, `pwr_en`, `refclk_en`, `train_en`, `done` and `fail` are 0.
- R2: A `start` sampled high while idle, done or failed sets `clk_en` after that same clock edge (cycle 0). Every reset stays asserted and `ep_rst_n` stays low at that point.
- R3: `pwr_en` rises in cycle 1. `ifc_rst` falls in cycle 1+P, where P = PWR_US × (CLK_HZ / 1e6).
- R4: `refclk_en` rises I cycles after `ifc_rst` falls, where I = IFC_US × (CLK_HZ / 1e6).
- R5: `phy_rst`, `core_rst`, `por_rst` and `bus_rst` fall in that order, one per cycle. The first falls one cycle after `refclk_en` rises.
- R6: `ep_rst_n` and `train_en` rise together, A+1 cycles after `bus_rst` falls, where A = ACQ_US × (CLK_HZ / 1e6).
- R7: `link_up` is sampled at the clock edge Q+1 cycles after `train_en` rises, then every Q cycles after that, where Q = POLL_US × (CLK_HZ / 1e6). The first high sample sets `done` after that edge.
- R8: If none of POLL_MAX samples is high, `fail` rises after the last sampling edge. In that same cycle all five domain resets are 1, `ep_rst_n` is 0, and `clk_en`, `pwr_en`, `refclk_en` and `train_en` are 0.
- R9: `done` and `fail` are never both high. Each holds its value whatever `link_up` does, until the next `start`.
- R10: A `start` pulse while a sequence is in progress has no effect on the timing or the outcome of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches the sequence when idle, done or failed |
| link_up | input | 1 | Link-up status from the port |
| ep_rst_n | output | 1 | Endpoint reset pin, active low |
| pwr_en | output | 1 | Slot power enable |
| clk_en | output | 1 | Port clock gate enable |
| refclk_en | output | 1 | Reference clock enable |
| ifc_rst | output | 1 | Interface-logic reset, active high |
| phy_rst | output | 1 | PHY reset, active high |
| core_rst | output | 1 | Core reset, active high |
| por_rst | output | 1 | Power-on reset, active high |
| bus_rst | output | 1 | Bus-clock-domain reset, active high |
| train_en | output | 1 | Link training enable |
| done | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky link-up timeout flag |

## Verification
The bench aims at the edges of the poll window:
- Link-up going high one cycle before the first sample, and exactly at it. A design that samples one cycle late or early would finish one poll interval off.
- Link-up arriving just in time for the last allowed sample, and one cycle too late for it. An off-by-one poll count would turn that last-chance success into a timeout, or grant an extra sample.
- Start pulses injected mid-sequence. These catch a design that restarts or stretches its waits on them.
- Checks after a timeout. These catch any enable left on or any reset left released.

// File: rtl/rp_pwrup_pkg.sv
// Shared types for the root port power-up sequencer.
// Assumes the state encoding is ordered: pins that stay on run from
// the state that turns them on through ST_DONE.
package rp_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CLKON  = 4'd1,
        ST_PWR    = 4'd2,
        ST_IFCREL = 4'd3,
        ST_REFCLK = 4'd4,
        ST_PHYREL = 4'd5,
        ST_CORREL = 4'd6,
        ST_PORREL = 4'd7,
        ST_BUSREL = 4'd8,
        ST_ACQ    = 4'd9,
        ST_EPREL  = 4'd10,
        ST_POLL   = 4'd11,
        ST_DONE   = 4'd12,
        ST_FAIL   = 4'd13
    } seq_st_t;

    typedef struct packed {
        logic ep_rst_n;
        logic pwr_en;
        logic clk_en;
        logic refclk_en;
        logic ifc_rst;
        logic phy_rst;
        logic core_rst;
        logic por_rst;
        logic bus_rst;
        logic train_en;
        logic done;
        logic fail;
    } pins_t;

    // True when state s lies between lo and the success state
    function automatic logic in_span(seq_st_t s, seq_st_t lo);
        return (s >= lo) && (s <= ST_DONE);
    endfunction

    // Pin levels that belong to a state
    function automatic pins_t decode(seq_st_t s);
        pins_t p;
        p.clk_en    = in_span(s, ST_CLKON);
        p.pwr_en    = in_span(s, ST_PWR);
        p.ifc_rst   = !in_span(s, ST_IFCREL);
        p.refclk_en = in_span(s, ST_REFCLK);
        p.phy_rst   = !in_span(s, ST_PHYREL);
        p.core_rst  = !in_span(s, ST_CORREL);
        p.por_rst   = !in_span(s, ST_PORREL);
        p.bus_rst   = !in_span(s, ST_BUSREL);
        p.ep_rst_n  = in_span(s, ST_EPREL);
        p.train_en  = in_span(s, ST_EPREL);
        p.done      = (s == ST_DONE);
        p.fail      = (s == ST_FAIL);
        return p;
    endfunction

endpackage

// File: rtl/rp_delay_timer.sv
// Down-counter for settle waits.
// Assumes load takes priority; zero stays high once the count reaches 0.
module rp_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new wait length or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rp_poll_counter.sv
// Counts failed link-up samples.
// Assumes LIMIT >= 1; last flags that the next sample is the final one.
module rp_poll_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Restart at the window entry, step on each low sample
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rp_pwrup_outreg.sv
// Registers the pin vector so every output leaves a flop.
// Assumes its input is the decoded next state; reset loads the idle pins.
module rp_pwrup_outreg
    import rp_pwrup_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_d,
    output pins_t pins_q
);
    // Capture the decoded pins, with safe levels under reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pins_q <= decode(ST_IDLE);
        else
            pins_q <= pins_d;
    end
endmodule

// File: rtl/rp_pwrup_seq.sv
// Root port power-up reset sequencer (top).
// Assumes every derived wait is at least one cycle and that link_up is
// already synchronous to clk.
module rp_pwrup_seq
    import rp_pwrup_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned PWR_US   = 3000,
    parameter int unsigned IFC_US   = 1,
    parameter int unsigned ACQ_US   = 150,
    parameter int unsigned POLL_US  = 10000,
    parameter int unsigned POLL_MAX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic link_up,
    output logic ep_rst_n,
    output logic pwr_en,
    output logic clk_en,
    output logic refclk_en,
    output logic ifc_rst,
    output logic phy_rst,
    output logic core_rst,
    output logic por_rst,
    output logic bus_rst,
    output logic train_en,
    output logic done,
    output logic fail
);
    localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int unsigned PWR_CYC    = PWR_US * CYC_PER_US;
    localparam int unsigned IFC_CYC    = IFC_US * CYC_PER_US;
    localparam int unsigned ACQ_CYC    = ACQ_US * CYC_PER_US;
    localparam int unsigned POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int unsigned MAX_A      = (PWR_CYC > IFC_CYC) ? PWR_CYC : IFC_CYC;
    localparam int unsigned MAX_B      = (ACQ_CYC > POLL_CYC) ? ACQ_CYC : POLL_CYC;
    localparam int unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int          TW         = $clog2(MAX_CYC + 1);

    seq_st_t       st_q, st_d;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          poll_clear, poll_bump, poll_last;
    logic          sample_now;
    pins_t         pins_q;

    assign sample_now = (st_q == ST_POLL) && tmr_zero;

    // Next-state walk through the release order
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) st_d = ST_CLKON;
            ST_CLKON:  st_d = ST_PWR;
            ST_PWR:    if (tmr_zero) st_d = ST_IFCREL;
            ST_IFCREL: if (tmr_zero) st_d = ST_REFCLK;
            ST_REFCLK: st_d = ST_PHYREL;
            ST_PHYREL: st_d = ST_CORREL;
            ST_CORREL: st_d = ST_PORREL;
            ST_PORREL: st_d = ST_BUSREL;
            ST_BUSREL: st_d = ST_ACQ;
            ST_ACQ:    if (tmr_zero) st_d = ST_EPREL;
            ST_EPREL:  st_d = ST_POLL;
            ST_POLL: begin
                if (sample_now) begin
                    if (link_up)        st_d = ST_DONE;
                    else if (poll_last) st_d = ST_FAIL;
                end
            end
            default:   st_d = ST_IDLE;
        endcase
    end

    // Wait length for the state being entered
    always_comb begin
        unique case (st_d)
            ST_PWR:    tmr_val = TW'(PWR_CYC - 1);
            ST_IFCREL: tmr_val = TW'(IFC_CYC - 1);
            ST_ACQ:    tmr_val = TW'(ACQ_CYC - 1);
            ST_POLL:   tmr_val = TW'(POLL_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    assign tmr_load   = (st_d != st_q) || (sample_now && st_d == ST_POLL);
    assign poll_clear = (st_d == ST_POLL) && (st_q != ST_POLL);
    assign poll_bump  = sample_now && !link_up;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    rp_delay_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rp_poll_counter #(.LIMIT(POLL_MAX)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .bump  (poll_bump),
        .last  (poll_last)
    );

    rp_pwrup_outreg u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_d (decode(st_d)),
        .pins_q (pins_q)
    );

    assign ep_rst_n  = pins_q.ep_rst_n;
    assign pwr_en    = pins_q.pwr_en;
    assign clk_en    = pins_q.clk_en;
    assign refclk_en = pins_q.refclk_en;
    assign ifc_rst   = pins_q.ifc_rst;
    assign phy_rst   = pins_q.phy_rst;
    assign core_rst  = pins_q.core_rst;
    assign por_rst   = pins_q.por_rst;
    assign bus_rst   = pins_q.bus_rst;
    assign train_en  = pins_q.train_en;
    assign done      = pins_q.done;
    assign fail      = pins_q.fail;
endmodule

// File: rtl/rp_pwrup_seq_chk.sv
// Temporal checks on the sequencer pins, bound to every instance.
// Assumes the pins are sampled on clk with rst_n as synchronous reset.
module rp_pwrup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic link_up,
    input logic ep_rst_n,
    input logic pwr_en,
    input logic clk_en,
    input logic refclk_en,
    input logic ifc_rst,
    input logic phy_rst,
    input logic core_rst,
    input logic por_rst,
    input logic bus_rst,
    input logic train_en,
    input logic done,
    input logic fail
);
    AST_IFC_AFTER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ifc_rst) |-> (pwr_en && $past(pwr_en) && clk_en)); // R3

    AST_PHY_AFTER_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> ($past(refclk_en) && !ifc_rst)); // R4

    AST_CORE_AFTER_PHY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> $past(!phy_rst)); // R5

    AST_POR_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_rst) |-> $past(!core_rst)); // R5

    AST_BUS_AFTER_POR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rst) |-> $past(!por_rst)); // R5

    AST_EP_AFTER_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_rst_n) |-> ($past(!bus_rst) && train_en)); // R6

    AST_FAIL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (ifc_rst && phy_rst && core_rst && por_rst && bus_rst
                         && !ep_rst_n && !pwr_en && !clk_en && !refclk_en
                         && !train_en)); // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R9

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9

    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R9

    AST_DONE_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(link_up)); // R7
endmodule

bind rp_pwrup_seq rp_pwrup_seq_chk u_chk (.*);

// File: tb/rp_pwrup_seq_test.sv
`timescale 1ns/1ps
module rp_pwrup_seq_test;
    localparam int CLK_HZ   = 2_000_000;
    localparam int PWR_US   = 20;
    localparam int IFC_US   = 2;
    localparam int ACQ_US   = 15;
    localparam int POLL_US  = 10;
    localparam int POLL_MAX = 5;
    localparam int CPU  = CLK_HZ / 1_000_000;
    localparam int P    = PWR_US * CPU;
    localparam int I    = IFC_US * CPU;
    localparam int A    = ACQ_US * CPU;
    localparam int Q    = POLL_US * CPU;
    localparam int T0   = 7 + P + I + A;
    localparam int TEND = T0 + POLL_MAX * Q;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic link_up = 1'b0;
    logic ep_rst_n, pwr_en, clk_en, refclk_en, ifc_rst, phy_rst;
    logic core_rst, por_rst, bus_rst, train_en, done, fail;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #2.5 clk = ~clk;

    rp_pwrup_seq #(
        .CLK_HZ(CLK_HZ), .PWR_US(PWR_US), .IFC_US(IFC_US),
        .ACQ_US(ACQ_US), .POLL_US(POLL_US), .POLL_MAX(POLL_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
        .ep_rst_n(ep_rst_n), .pwr_en(pwr_en), .clk_en(clk_en),
        .refclk_en(refclk_en), .ifc_rst(ifc_rst), .phy_rst(phy_rst),
        .core_rst(core_rst), .por_rst(por_rst), .bus_rst(bus_rst),
        .train_en(train_en), .done(done), .fail(fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected end cycle and outcome for link-up high from cycle L on
    function automatic int exp_end(input int L, output bit ok);
        for (int k = 1; k <= POLL_MAX; k++) begin
            if (T0 + k * Q >= L + 1) begin
                ok = 1'b1;
                return T0 + k * Q;
            end
        end
        ok = 1'b0;
        return TEND;
    endfunction

    // Safe idle/fail pin vector: ep_rst_n,pwr,clk,ref,5 resets,train
    function automatic int safe_pins();
        return {ep_rst_n, pwr_en, clk_en, refclk_en, ifc_rst, phy_rst,
                core_rst, por_rst, bus_rst, train_en};
    endfunction

    task automatic run_seq(input int L, input bit mid_start);
        int ev[10];
        int cyc;
        int endc;
        bit ok;
        bit got_done, got_fail, held;
        for (int i = 0; i < 10; i++) ev[i] = -1;
        @(negedge clk);
        start = 1'b1;
        link_up = 1'b0;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        forever begin
            if (ev[0] < 0 && clk_en)    ev[0] = cyc;
            if (ev[1] < 0 && pwr_en)    ev[1] = cyc;
            if (ev[2] < 0 && !ifc_rst)  ev[2] = cyc;
            if (ev[3] < 0 && refclk_en) ev[3] = cyc;
            if (ev[4] < 0 && !phy_rst)  ev[4] = cyc;
            if (ev[5] < 0 && !core_rst) ev[5] = cyc;
            if (ev[6] < 0 && !por_rst)  ev[6] = cyc;
            if (ev[7] < 0 && !bus_rst)  ev[7] = cyc;
            if (ev[8] < 0 && ep_rst_n)  ev[8] = cyc;
            if (ev[9] < 0 && train_en)  ev[9] = cyc;
            if (done || fail || cyc > TEND + 20) break;
            @(negedge clk);
            cyc++;
            start = mid_start && (cyc == 3 || cyc == T0 + 1);
            link_up = (cyc >= L);
        end
        start = 1'b0;
        endc = exp_end(L, ok);
        chk("R2 clk_en rise", ev[0], 0);
        chk("R3 pwr_en rise", ev[1], 1);
        chk("R3 ifc_rst release", ev[2], 1 + P);
        chk("R4 refclk_en rise", ev[3], 1 + P + I);
        chk("R5 phy_rst release", ev[4], 2 + P + I);
        chk("R5 core_rst release", ev[5], 3 + P + I);
        chk("R5 por_rst release", ev[6], 4 + P + I);
        chk("R5 bus_rst release", ev[7], 5 + P + I);
        chk("R6 ep_rst_n release", ev[8], 6 + P + I + A);
        chk("R6 train_en rise", ev[9], 6 + P + I + A);
        if (ok) chk("R7 done cycle", cyc, endc);
        else    chk("R8 fail cycle", cyc, endc);
        chk("R7 R8 outcome done", int'(done), int'(ok));
        chk("R7 R8 outcome fail", int'(fail), int'(!ok));
        if (mid_start) chk("R10 end cycle with stray start", cyc, endc);
        if (!ok) chk("R8 pins after timeout", safe_pins(), 10'b0000111110);
        got_done = done;
        got_fail = fail;
        held = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            link_up = i[0];
            if (done != got_done || fail != got_fail) held = 1'b0;
        end
        chk("R9 flags sticky", int'(held), 1);
    endtask

    initial begin : watchdog
        while (cyc_total < 150_000) begin
            @(posedge clk);
            cyc_total++;
        end
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles",
                 cyc_total, 150_000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int L;
        bit ms;
        void'($urandom(32'd1789));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pins", safe_pins(), 10'b0000111110);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset fail", int'(fail), 0);
        repeat (5) @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        chk("R1 idle ignores link_up", safe_pins(), 10'b0000111110);

        run_seq(1, 1'b0);
        run_seq(T0 + Q - 1, 1'b0);
        run_seq(T0 + Q, 1'b1);
        run_seq(TEND - 1, 1'b0);
        run_seq(TEND, 1'b0);
        run_seq(100_000, 1'b1);
        run_seq(T0 + 2 * Q - 1, 1'b0);
        for (int r = 0; r < 14; r++) begin
            L = 1 + int'($urandom % (TEND + 10));
            ms = $urandom % 2;
            run_seq(L, ms);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule